// File: doc/BRIEF.md
# Erroneous-Segment Job Dispatcher

This block sits between a syndrome-based segmenter and a pair of parallel trellis decoders. The segmenter reports each erroneous stretch of the received stream as a half-open index range `[first, end)`. Both ends of such a range are points where the decoding path is known to sit in the all-zero state. The dispatcher turns every range into one or more decode jobs. A job is a start index, a length and two flags that say whether the decoder may assume a zero state at its beginning and at its end. The error-free stretches between ranges are never decoded: they only add to a skipped-step counter, which is kept for speed-up measurement.

A range longer than the cap `CAP_L` is cut into cores of `CAP_L` steps. Every core except the first gets an acquisition prefix of `5*K` steps taken from the previous core. Every core except the last gets a truncation suffix of `5*K` steps taken from the next core. Neighbouring jobs therefore overlap by `10*K` steps. Jobs go to the two decoders in strict alternation. A decoder holds its job until it pulses its done input. Ranges wait in a small FIFO, and the segmenter is back-pressured when that FIFO is full.

Top module: `gap_skip_dispatcher`

## Requirements
- R1: Right after reset, `seg_ready_o` is 1, both `job_valid_o` bits are 0 and both counters read 0.
- R2: A range of length 1 to `CAP_L` gives exactly one job with start = `first`, length = `end - first`, and both zero-state flags at 1 (1 means the state is known to be zero).
- R3: A range longer than `CAP_L` gives `ceil(len/CAP_L)` jobs. Job i covers core `[first + i*CAP_L, min(first + (i+1)*CAP_L, end))`. Its start is the core start minus `5*K` when i > 0. Its length is the core length plus `5*K` when i > 0, plus another `5*K` when it is not the last job. The initial-zero flag is 1 only for i = 0, and the final-zero flag is 1 only for the last job.
- R4: The n-th job accepted after reset (counting from 0) is offered only on port n mod 2 (bit 0 or bit 1 of `job_valid_o`).
- R5: A port is not offered a job while its decoder holds an outstanding one. A job is outstanding from its handshake until a one-cycle pulse on that port's `job_done_i` bit. A done pulse on a port with no outstanding job has no effect.
- R6: While a port is valid and not ready, it stays valid and its start, length and flags stay unchanged.
- R7: A zero-length range, and the gaps between ranges, produce no job.
- R8: If no job is accepted, the block takes exactly `FIFO_DEPTH + 1` non-empty ranges, and then holds `seg_ready_o` at 0.
- R9: `jobs_issued_o` counts job handshakes on both ports.
- R10: `skipped_steps_o` is the sum of `first - previous end` over all ranges taken, where the previous end starts at 0 after reset. Jobs come out in range order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid_i | input | 1 | Segmenter offers a range |
| seg_ready_o | output | 1 | Range FIFO has room |
| seg_first_i | input | IDX_W | First index of the erroneous range |
| seg_end_i | input | IDX_W | Index one past the end of the range |
| job_valid_o | output | 2 | Job offered to decoder 0 / decoder 1 |
| job_ready_i | input | 2 | Decoder 0 / 1 accepts the offered job |
| job_start_o | output | IDX_W | Start index of the offered job |
| job_len_o | output | IDX_W | Length of the offered job in steps |
| job_init_zero_o | output | 1 | Job starts in the known zero state |
| job_final_zero_o | output | 1 | Job ends in the known zero state |
| job_done_i | input | 2 | One-cycle completion pulse from decoder 0 / 1 |
| jobs_issued_o | output | CNT_W | Number of jobs handed out |
| skipped_steps_o | output | CNT_W | Error-free steps that were never decoded |

## Verification
The bench builds the block with `CAP_L = 24`, `K = 3` and `FIFO_DEPTH = 4`. With these values the overlap margin is 15 steps per side, and a range needs only 25 steps to split. Directed ranges of exactly the cap, one step past it and several caps plus a remainder exercise the first, middle and last subblock shapes. Random ranges of up to about three caps mix those shapes with empty ranges. Random ready and done timing, including done pulses on idle ports, covers the stall and alternation rules. A phase with both decoders frozen fills the FIFO to its depth.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;

    localparam int IDX_W = 16;

    typedef logic [IDX_W-1:0] idx_t;

    // erroneous range [first, stop)
    typedef struct packed {
        idx_t first;
        idx_t stop;
    } seg_t;

    typedef struct packed {
        idx_t start;
        idx_t len;
        logic init_zero;
        logic final_zero;
    } job_t;

endpackage

// File: rtl/seg_fifo.sv
module seg_fifo
    import seg_disp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_valid,
    input  seg_t push_data,
    output logic push_ready,
    output logic pop_valid,
    output seg_t pop_data,
    input  logic pop_en
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_C = PTR_W'(DEPTH - 1);

    typedef struct packed {
        seg_t [DEPTH-1:0]  mem;
        logic [PTR_W-1:0]  wr;
        logic [PTR_W-1:0]  rd;
        logic [CNT_W-1:0]  cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push, pop;

    always_comb begin
        st_d       = st_q;
        push_ready = (st_q.cnt != FULL_C);
        pop_valid  = (st_q.cnt != '0);
        pop_data   = st_q.mem[st_q.rd];
        push       = push_valid && push_ready;
        pop        = pop_en && pop_valid;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == LAST_C) ? '0 : st_q.wr + PTR_W'(1);
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LAST_C) ? '0 : st_q.rd + PTR_W'(1);
        end
        if (push && !pop) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (pop && !push) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready && !pop_en) |=> (st_q.cnt == FULL_C));

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_C);

endmodule

// File: rtl/job_splitter.sv
module job_splitter
    import seg_disp_pkg::*;
#(
    parameter int CAP_L = 150,
    parameter int K     = 7,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_valid,
    input  seg_t             seg,
    output logic             seg_take,
    output logic             job_valid,
    output job_t             job,
    input  logic             job_take,
    output logic [CNT_W-1:0] skip_cnt
);

    localparam idx_t CAP_C   = idx_t'(CAP_L);
    localparam idx_t ACQ_C   = idx_t'(5 * K);
    localparam idx_t TRUNC_C = idx_t'(5 * K);
    localparam idx_t MAXLEN_C = idx_t'(CAP_L + 10 * K);

    typedef struct packed {
        logic             active;
        logic             first;
        idx_t             cur;
        idx_t             stop;
        idx_t             prev_end;
        logic [CNT_W-1:0] skipped;
    } split_st_t;

    split_st_t st_d, st_q;
    idx_t remaining, core;
    logic last;

    always_comb begin
        st_d      = st_q;
        remaining = st_q.stop - st_q.cur;
        last      = (remaining <= CAP_C);
        core      = last ? remaining : CAP_C;

        job.start      = st_q.first ? st_q.cur : st_q.cur - ACQ_C;
        job.len        = core + (st_q.first ? '0 : ACQ_C) + (last ? '0 : TRUNC_C);
        job.init_zero  = st_q.first;
        job.final_zero = last;
        job_valid      = st_q.active;

        seg_take = !st_q.active && seg_valid;
        if (seg_take) begin
            st_d.skipped  = st_q.skipped + CNT_W'(seg.first - st_q.prev_end);
            st_d.prev_end = seg.stop;
            st_d.cur      = seg.first;
            st_d.stop     = seg.stop;
            st_d.first    = 1'b1;
            st_d.active   = (seg.stop != seg.first);
        end
        if (st_q.active && job_take) begin
            if (last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cur   = st_q.cur + CAP_C;
                st_d.first = 1'b0;
            end
        end
        skip_cnt = st_q.skipped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    split_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> (job.len <= MAXLEN_C));

    // R7
    split_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> (job.len != '0));

    // R3
    split_cursor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && job_take && !job.final_zero) |=> (job_valid && !job.init_zero));

endmodule

// File: rtl/gap_skip_dispatcher.sv
module gap_skip_dispatcher
    import seg_disp_pkg::*;
#(
    parameter int CAP_L      = 150,
    parameter int K          = 7,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_valid_i,
    output logic             seg_ready_o,
    input  logic [IDX_W-1:0] seg_first_i,
    input  logic [IDX_W-1:0] seg_end_i,
    output logic [1:0]       job_valid_o,
    input  logic [1:0]       job_ready_i,
    output logic [IDX_W-1:0] job_start_o,
    output logic [IDX_W-1:0] job_len_o,
    output logic             job_init_zero_o,
    output logic             job_final_zero_o,
    input  logic [1:0]       job_done_i,
    output logic [CNT_W-1:0] jobs_issued_o,
    output logic [CNT_W-1:0] skipped_steps_o
);

    typedef struct packed {
        logic             turn;
        logic [1:0]       busy;
        logic [CNT_W-1:0] issued;
    } disp_st_t;

    disp_st_t st_d, st_q;
    seg_t in_seg, head_seg;
    logic head_valid, head_take;
    logic job_avail, take;
    logic [1:0] hs;
    job_t cur_job;

    assign in_seg = '{first: seg_first_i, stop: seg_end_i};

    seg_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (seg_valid_i),
        .push_data  (in_seg),
        .push_ready (seg_ready_o),
        .pop_valid  (head_valid),
        .pop_data   (head_seg),
        .pop_en     (head_take)
    );

    job_splitter #(.CAP_L(CAP_L), .K(K), .CNT_W(CNT_W)) split_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_valid (head_valid),
        .seg       (head_seg),
        .seg_take  (head_take),
        .job_valid (job_avail),
        .job       (cur_job),
        .job_take  (take),
        .skip_cnt  (skipped_steps_o)
    );

    always_comb begin
        st_d        = st_q;
        job_valid_o = {2{job_avail}} & ~st_q.busy & {st_q.turn, ~st_q.turn};
        hs          = job_valid_o & job_ready_i;
        take        = |hs;
        st_d.busy   = (st_q.busy & ~job_done_i) | hs;
        st_d.turn   = st_q.turn ^ take;
        st_d.issued = st_q.issued + CNT_W'(take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign job_start_o      = cur_job.start;
    assign job_len_o        = cur_job.len;
    assign job_init_zero_o  = cur_job.init_zero;
    assign job_final_zero_o = cur_job.final_zero;
    assign jobs_issued_o    = st_q.issued;

    // R4
    alt_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs[0] |=> !job_valid_o[0]);

    // R4
    alt_port1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs[1] |=> !job_valid_o[1]);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid_o[0] && !job_ready_i[0]) |=>
            (job_valid_o[0] && $stable(job_start_o) && $stable(job_len_o)));

    // R9
    issue_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (jobs_issued_o != $past(jobs_issued_o)));

endmodule

// File: tb/gap_skip_dispatcher_tb_top.sv
`timescale 1ns/1ps
module gap_skip_dispatcher_tb_top;
    import seg_disp_pkg::*;

    localparam int CAP_L = 24;
    localparam int K     = 3;
    localparam int DEPTH = 4;
    localparam int CNT_W = 32;
    localparam int MARGIN = 5 * K;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seg_valid_i = 1'b0;
    logic seg_ready_o;
    idx_t seg_first_i = '0;
    idx_t seg_end_i = '0;
    logic [1:0] job_valid_o;
    logic [1:0] job_ready_i = '0;
    idx_t job_start_o, job_len_o;
    logic job_init_zero_o, job_final_zero_o;
    logic [1:0] job_done_i = '0;
    logic [CNT_W-1:0] jobs_issued_o, skipped_steps_o;

    always #5 clk = ~clk;

    gap_skip_dispatcher #(.CAP_L(CAP_L), .K(K), .FIFO_DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .seg_valid_i(seg_valid_i), .seg_ready_o(seg_ready_o),
        .seg_first_i(seg_first_i), .seg_end_i(seg_end_i),
        .job_valid_o(job_valid_o), .job_ready_i(job_ready_i),
        .job_start_o(job_start_o), .job_len_o(job_len_o),
        .job_init_zero_o(job_init_zero_o), .job_final_zero_o(job_final_zero_o),
        .job_done_i(job_done_i),
        .jobs_issued_o(jobs_issued_o), .skipped_steps_o(skipped_steps_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    seg_t pend[$];
    job_t exp_jobs[$];
    logic [1:0] busy_b = '0;
    int tmr[2];
    logic exp_port = 1'b0;
    logic [1:0] held = '0;
    job_t held_job;
    int issued_b = 0, accepted = 0;
    longint skip_b = 0;
    int prev_end_b = 0;
    int nxt = 10;
    bit hold_dec = 0, hold_seg = 0, idle_done = 0, rnd_ready = 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected jobs for one range, from R2 / R3 / R7
    function automatic void build_jobs(input int s, input int e);
        int cur = s;
        bit first = 1;
        if (e == s) return;
        while (1) begin
            int rem = e - cur;
            bit last = (rem <= CAP_L);
            int core = last ? rem : CAP_L;
            job_t j;
            j.start      = idx_t'(first ? cur : cur - MARGIN);
            j.len        = idx_t'(core + (first ? 0 : MARGIN) + (last ? 0 : MARGIN));
            j.init_zero  = first;
            j.final_zero = last;
            exp_jobs.push_back(j);
            if (last) break;
            cur += CAP_L;
            first = 0;
        end
    endfunction

    task automatic add_seg(input int gap, input int len);
        seg_t s;
        s.first = idx_t'(nxt + gap);
        s.stop  = idx_t'(nxt + gap + len);
        nxt = nxt + gap + len;
        pend.push_back(s);
    endtask

    task automatic step();
        job_t got;
        logic [1:0] hs;
        @(negedge clk);
        cyc++;
        seg_valid_i = (pend.size() != 0) && !hold_seg;
        if (pend.size() != 0) begin
            seg_first_i = pend[0].first;
            seg_end_i   = pend[0].stop;
        end
        for (int k = 0; k < 2; k++) begin
            job_done_i[k] = 1'b0;
            if (busy_b[k]) begin
                if (tmr[k] == 0) job_done_i[k] = 1'b1;
                else tmr[k]--;
            end else if (idle_done || ($urandom % 8 == 0)) begin
                job_done_i[k] = 1'b1;   // R5: done while idle must be ignored
            end
            job_ready_i[k] = hold_dec ? 1'b0 : (rnd_ready ? ($urandom % 4 != 0) : 1'b1);
        end
        #1;
        got = '{start: job_start_o, len: job_len_o,
                init_zero: job_init_zero_o, final_zero: job_final_zero_o};
        for (int k = 0; k < 2; k++) begin
            if (held[k]) begin
                chk(job_valid_o[k] == 1'b1, "R6 valid held", job_valid_o[k], 1);
                chk(got == held_job, "R6 payload held", got, held_job);
            end
            if (job_valid_o[k]) begin
                chk(!busy_b[k], "R5 offer to busy decoder", busy_b[k], 0);
                chk(k == int'(exp_port), "R4 alternation port", k, exp_port);
            end
        end
        for (int k = 0; k < 2; k++) if (job_done_i[k]) busy_b[k] = 1'b0;
        hs = job_valid_o & job_ready_i;
        for (int k = 0; k < 2; k++) begin
            if (hs[k]) begin
                if (exp_jobs.size() == 0) begin
                    chk(0, "R7 unexpected job", got.start, -1);
                end else begin
                    job_t e = exp_jobs.pop_front();
                    string tg = (e.init_zero && e.final_zero) ? "R2" : "R3";
                    chk(got.start == e.start, {tg, " start"}, got.start, e.start);
                    chk(got.len == e.len, {tg, " length"}, got.len, e.len);
                    chk({got.init_zero, got.final_zero} == {e.init_zero, e.final_zero},
                        {tg, " zero flags"}, {got.init_zero, got.final_zero},
                        {e.init_zero, e.final_zero});
                end
                exp_port = ~exp_port;
                busy_b[k] = 1'b1;
                tmr[k] = $urandom % 4;
                issued_b++;
            end
            held[k] = job_valid_o[k] && !job_ready_i[k];
        end
        held_job = got;
        if (seg_valid_i && seg_ready_o) begin
            seg_t s = pend.pop_front();
            skip_b += int'(s.first) - prev_end_b;
            prev_end_b = int'(s.stop);
            build_jobs(int'(s.first), int'(s.stop));
            accepted++;
        end
    endtask

    task automatic drain();
        while ((pend.size() != 0 || exp_jobs.size() != 0 || busy_b != 0) && cyc < LIMIT) step();
        repeat (4) step();
    endtask

    initial begin
        int acc0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(seg_ready_o == 1'b1, "R1 seg_ready", seg_ready_o, 1);
        chk(job_valid_o == 2'b00, "R1 job_valid", job_valid_o, 0);
        chk(jobs_issued_o == 0, "R1 jobs_issued", jobs_issued_o, 0);
        chk(skipped_steps_o == 0, "R1 skipped", skipped_steps_o, 0);

        // R5 done pulses on idle ports before anything is issued
        idle_done = 1;
        repeat (3) step();
        idle_done = 0;

        // directed shapes: exact cap (R2), cap+1 (R3), empty (R7), long (R3), single step (R2)
        add_seg(0, CAP_L);
        add_seg(3, CAP_L + 1);
        add_seg(5, 0);
        add_seg(2, 3 * CAP_L + 5);
        add_seg(0, 1);
        add_seg(7, 2 * CAP_L);
        drain();

        // R8 back-pressure with both decoders frozen
        hold_dec = 1;
        acc0 = accepted;
        for (int i = 0; i < 7; i++) add_seg(2, 5);
        repeat (20) step();
        chk(accepted - acc0 == DEPTH + 1, "R8 ranges taken while stalled", accepted - acc0, DEPTH + 1);
        chk(seg_ready_o == 1'b0, "R8 seg_ready low when full", seg_ready_o, 0);
        hold_dec = 0;
        drain();

        // random mix
        for (int i = 0; i < 150; i++) begin
            int len = ($urandom % 4 == 0) ? int'($urandom % 3) : int'($urandom % (3 * CAP_L + 10));
            add_seg(int'($urandom % 12), len);
        end
        for (int i = 0; i < 3000 && pend.size() != 0; i++) begin
            hold_seg = ($urandom % 5 == 0);
            step();
        end
        hold_seg = 0;
        drain();

        if (cyc >= LIMIT) chk(0, "watchdog expired", cyc, LIMIT);
        chk(exp_jobs.size() == 0, "R10 all jobs in order", exp_jobs.size(), 0);
        chk(jobs_issued_o == CNT_W'(issued_b), "R9 jobs_issued", jobs_issued_o, issued_b);
        chk(longint'(skipped_steps_o) == skip_b, "R10 skipped steps", skipped_steps_o, skip_b);
        chk(job_valid_o == 2'b00, "R7 no job after last range", job_valid_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule